// File: doc/BRIEF.md
# Serial NRZI Receive Deserializer with Loopback Source

This block sits on the receive side of a serial line, after clock recovery. It runs entirely on the recovered bit clock. Each bit clock it takes one line bit, turns the transition-coded NRZI level back into a plain NRZ bit, and shifts that bit into a five-bit symbol. A modulo-5 phase counter marks the symbol boundaries and produces a symbol clock at one fifth of the bit rate. The completed symbol appears on the parallel output on the bit-clock edge where the symbol clock falls.

An active-low loopback select takes the serial input from the local transmit stream instead of the line. This lets a system test its own transmit and receive paths without the medium. An external signal-detect level is passed through a two-stage synchronizer that advances on symbol-clock rising edges, and comes out with the same polarity.

Symbol alignment, 5-bit code decoding, clock recovery and the analog line receivers are handled elsewhere.

Top module: `nrzi_rx_deser`

## Requirements
- R1: The decoded bit is 1 when the selected serial input differs from its level one bit clock earlier, and 0 when the two are equal. The remembered previous level is 0 after reset.
- R2: Five consecutive decoded bits form one symbol. The bit taken first lands in `sym_data[4]` and the bit taken fifth in `sym_data[0]`. After reset release, bit clock edges 0 to 4 carry the first symbol.
- R3: `sym_clk` has a period of exactly five bit clocks: high for two and low for three. After reset release it first goes high at the third bit clock edge (edge index 2).
- R4: `sym_data` changes only on the bit clock edge where `sym_clk` falls (edge indices 4, 9, 14, ...), and it holds its value at every other edge.
- R5: `sig_det_out` has the same polarity as `sig_det_in`. The input is sampled at each `sym_clk` rising edge and appears at the output one symbol later, at the next rising edge. The output changes at no other time.
- R6: With `loop_n` = 0 the serial input is `tx_loop_in`, and `line_in` has no effect on `sym_data`.
- R7: With `loop_n` = 1 the serial input is `line_in`, and `tx_loop_in` has no effect on `sym_data`.
- R8: While `rst` is high at a bit clock edge, the edge clears `sym_data`, `sym_clk` and `sig_det_out` to 0 and restarts the symbol phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Serial NRZI stream from the line |
| tx_loop_in | input | 1 | Serial NRZI stream from the local transmitter |
| loop_n | input | 1 | Loopback select, active low |
| sig_det_in | input | 1 | External signal-detect level |
| sym_clk | output | 1 | Symbol clock, bit clock divided by five |
| sym_data | output | 5 | Received NRZ symbol, bit 4 first received |
| sig_det_out | output | 1 | Signal detect resynchronized to the symbol clock |

## Verification
After the reset edge, edge index n has the phase counter at n mod 5. With E edges completed, `sym_clk` is high when E mod 5 is 3 or 4. Symbol j becomes visible once 5j+5 edges are done. Signal detect shows the value the input held at edge 5(m-1)+2, where m is the largest integer with 5m+2 ≤ E-1. The bench drives one bit per cycle on the falling clock edge, counts completed edges, and compares against these arithmetic expressions at every falling edge. It does this for all 32 symbol values, in both the line and the loopback selection, with the unused input toggling.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

    localparam int SYM_BITS = 5;
    localparam int PHASE_W  = $clog2(SYM_BITS);

    typedef logic [SYM_BITS-1:0] sym_t;
    typedef logic [PHASE_W-1:0]  phase_t;

    // phase in which the last bit of a symbol is consumed
    localparam phase_t LAST_PHASE = phase_t'(SYM_BITS - 1);
    // phase whose edge raises the symbol clock
    localparam phase_t RISE_PHASE = phase_t'(SYM_BITS / 2);

    typedef struct packed {
        logic last;   // edge completes a symbol, symbol clock falls
        logic rise;   // edge raises the symbol clock
    } phase_evt_t;

    function automatic logic nrzi_to_nrz(input logic cur, input logic prev);
        return cur ^ prev;
    endfunction

    function automatic phase_t phase_next(input phase_t p);
        return (p == LAST_PHASE) ? '0 : phase_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/nrzi_src_decode.sv
module nrzi_src_decode
    import nrzi_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic tx_loop_in,
    input  logic loop_n,
    output logic nrz_bit
);

    logic sel_bit;
    logic prev_q;

    always_comb begin
        sel_bit = loop_n ? line_in : tx_loop_in;
        nrz_bit = nrzi_to_nrz(sel_bit, prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sel_bit;
    end

endmodule

// File: rtl/sym_phase_gen.sv
module sym_phase_gen
    import nrzi_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output phase_evt_t evt,
    output logic       sym_clk
);

    phase_t phase_q;
    logic   clk_div_q;

    always_comb begin
        evt.last = (phase_q == LAST_PHASE);
        evt.rise = (phase_q == RISE_PHASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= '0;
            clk_div_q <= 1'b0;
        end else begin
            phase_q   <= phase_next(phase_q);
            clk_div_q <= (phase_q >= RISE_PHASE) && (phase_q < LAST_PHASE);
        end
    end

    assign sym_clk = clk_div_q;

endmodule

// File: rtl/sym_assembler.sv
module sym_assembler
    import nrzi_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nrz_bit,
    input  logic last,
    output sym_t sym_data
);

    sym_t shift_q;
    sym_t out_q;
    sym_t shift_d;

    assign shift_d = {shift_q[SYM_BITS-2:0], nrz_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            out_q   <= '0;
        end else begin
            shift_q <= shift_d;
            if (last) out_q <= shift_d;
        end
    end

    assign sym_data = out_q;

endmodule

// File: rtl/sd_resync.sv
module sd_resync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst)     chain_q[0] <= 1'b0;
                    else if (en) chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst)     chain_q[i] <= 1'b0;
                    else if (en) chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nrzi_rx_deser.sv
module nrzi_rx_deser
    import nrzi_rx_pkg::*;
#(
    parameter int SD_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_in,
    input  logic                tx_loop_in,
    input  logic                loop_n,
    input  logic                sig_det_in,
    output logic                sym_clk,
    output logic [SYM_BITS-1:0] sym_data,
    output logic                sig_det_out
);

    logic       nrz_bit;
    phase_evt_t evt;

    nrzi_src_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .line_in    (line_in),
        .tx_loop_in (tx_loop_in),
        .loop_n     (loop_n),
        .nrz_bit    (nrz_bit)
    );

    sym_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sym_clk (sym_clk)
    );

    sym_assembler u_asm (
        .clk      (clk),
        .rst      (rst),
        .nrz_bit  (nrz_bit),
        .last     (evt.last),
        .sym_data (sym_data)
    );

    sd_resync #(.STAGES(SD_STAGES)) u_sd (
        .clk (clk),
        .rst (rst),
        .en  (evt.rise),
        .d   (sig_det_in),
        .q   (sig_det_out)
    );

endmodule

// File: rtl/nrzi_rx_deser_chk.sv
module nrzi_rx_deser_chk (
    input logic       clk,
    input logic       rst,
    input logic       sig_det_in,
    input logic       sym_clk,
    input logic [4:0] sym_data,
    input logic       sig_det_out
);

    logic       sym_clk_d;
    logic [1:0] rises_seen;
    logic       rise_now;

    assign rise_now = sym_clk && !sym_clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_clk_d  <= 1'b0;
            rises_seen <= '0;
        end else begin
            sym_clk_d <= sym_clk;
            if (rise_now && rises_seen != 2'd2) rises_seen <= rises_seen + 2'd1;
        end
    end

    assert_clk_high_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sym_clk) |=> sym_clk);

    assert_clk_low_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sym_clk) |=> !sym_clk ##1 !sym_clk ##1 sym_clk);

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$fell(sym_clk) |-> $stable(sym_data));

    // two stages, each one symbol (five bit clocks) apart, seen one sample later
    assert_sd_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (rise_now && rises_seen != 2'd0) |-> (sig_det_out == $past(sig_det_in, 6)));

    assert_sd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rise_now |-> $stable(sig_det_out));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (sym_data == 5'd0 && !sym_clk && !sig_det_out));

endmodule

bind nrzi_rx_deser nrzi_rx_deser_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sig_det_in  (sig_det_in),
    .sym_clk     (sym_clk),
    .sym_data    (sym_data),
    .sig_det_out (sig_det_out)
);

// File: tb/nrzi_rx_deser_tb.sv
module nrzi_rx_deser_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       line_in;
    logic       tx_loop_in;
    logic       loop_n;
    logic       sig_det_in;
    logic       sym_clk;
    logic [4:0] sym_data;
    logic       sig_det_out;

    int checks = 0;
    int fails  = 0;

    logic [4:0] syms [0:64];
    logic       sd_hist [0:511];

    always #5 clk = ~clk;

    nrzi_rx_deser u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_in     (line_in),
        .tx_loop_in  (tx_loop_in),
        .loop_n      (loop_n),
        .sig_det_in  (sig_det_in),
        .sym_clk     (sym_clk),
        .sym_data    (sym_data),
        .sig_det_out (sig_det_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // E = number of bit clock edges completed since reset release
    task automatic check_outputs(input int E, input bit use_loop);
        int   exp_data;
        int   m;
        logic exp_clk;
        logic exp_sd;
        exp_clk  = (E % 5 == 3) || (E % 5 == 4);
        exp_data = (E >= 5) ? int'(syms[E/5 - 1]) : 0;
        exp_sd   = 1'b0;
        if (E >= 3) begin
            m = (E - 3) / 5;
            if (m >= 1) exp_sd = sd_hist[5*(m-1) + 2];
        end
        chk(sym_clk == exp_clk, "R3 sym_clk", int'(sym_clk), int'(exp_clk));
        if (E % 5 != 0)
            chk(int'(sym_data) == exp_data, "R4 data hold", int'(sym_data), exp_data);
        else if (use_loop)
            chk(int'(sym_data) == exp_data, "R1 R2 R6 loopback symbol", int'(sym_data), exp_data);
        else
            chk(int'(sym_data) == exp_data, "R1 R2 R7 line symbol", int'(sym_data), exp_data);
        chk(sig_det_out == exp_sd, "R5 sig_det", int'(sig_det_out), int'(exp_sd));
    endtask

    task automatic run(input bit use_loop, input int nsym, input int seed);
        logic level;
        logic b;
        logic sd;
        for (int j = 0; j < nsym; j++) syms[j] = 5'((j * 13 + seed) % 32);
        syms[nsym] = 5'd0;
        @(negedge clk);
        rst        = 1'b1;
        loop_n     = !use_loop;
        line_in    = 1'b1;
        tx_loop_in = 1'b1;
        sig_det_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(sym_data == 5'd0 && !sym_clk && !sig_det_out, "R8 reset state",
            int'({sym_clk, sig_det_out, sym_data}), 0);
        rst   = 1'b0;
        level = 1'b0;
        for (int e = 0; e < nsym * 5 + 6; e++) begin
            check_outputs(e, use_loop);
            b     = (e < nsym * 5) ? syms[e/5][4 - (e % 5)] : 1'b0;
            level = level ^ b;
            if (use_loop) begin
                tx_loop_in = level;
                line_in    = ~line_in;
            end else begin
                line_in    = level;
                tx_loop_in = 1'(e % 2) ^ 1'((e / 3) % 2);
            end
            sd          = 1'(((e * 7) / 4) % 2) ^ 1'((e / 11) % 2);
            sd_hist[e]  = sd;
            sig_det_in  = sd;
            @(negedge clk);
        end
    endtask

    initial begin
        rst        = 1'b1;
        line_in    = 1'b0;
        tx_loop_in = 1'b0;
        loop_n     = 1'b1;
        sig_det_in = 1'b0;
        run(1'b0, 32, 5);
        run(1'b1, 32, 17);
        run(1'b0, 12, 30);
        run(1'b1, 12, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule